// File: doc/BRIEF.md
# I2C Target with Eight Configuration Registers

This block lets an I2C controller read and write a small bank of eight 8-bit configuration registers. It answers to one 7-bit device address, set as a parameter. The SCL and SDA lines are sampled with the system clock, so the block runs entirely in the system clock domain. SDA is driven through an open-drain enable: when `sda_oe` is high, the pad pulls SDA low.

A write transaction works like this. The controller sends the device address with the direction bit low. The next byte loads the register pointer. Each data byte after that is written into the register the pointer selects, at the moment the target acknowledges it. The pointer then advances by one and wraps from register 7 back to register 0.

A read transaction works like this. The controller first sets the pointer in a write phase. It then issues a repeated START and resends the device address with the direction bit high. The target returns the byte at the pointer. Each controller ACK fetches the next byte, and a NACK ends the read. All eight registers are always visible in parallel on `regs_o`, for the surrounding logic.

The state machine has nine states:
- `ST_IDLE`: waiting for START.
- `ST_ADDR`: shifting in the device address.
- `ST_ADDR_ACK`: acknowledging the device address.
- `ST_REGPTR`: shifting in the pointer byte.
- `ST_PTR_ACK`: acknowledging the pointer byte.
- `ST_WDATA`: shifting in a data byte.
- `ST_WDATA_ACK`: acknowledging a data byte, which commits it.
- `ST_RDATA`: shifting a byte out.
- `ST_RACK`: sampling the controller's ACK or NACK.

Transitions:
- From any state, START goes to `ST_ADDR` and STOP goes to `ST_IDLE`.
- After 8 address bits: on a match, go to `ST_ADDR_ACK`; otherwise go to `ST_IDLE`.
- From `ST_ADDR_ACK`: go to `ST_RDATA` for a read, or to `ST_REGPTR` for a write.
- From `ST_REGPTR`: go to `ST_PTR_ACK`, then to `ST_WDATA`.
- From `ST_WDATA`: go to `ST_WDATA_ACK`, then back to `ST_WDATA`.
- From `ST_RDATA`: go to `ST_RACK`.
- From `ST_RACK`: go back to `ST_RDATA` on ACK, or to `ST_IDLE` on NACK.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The first byte after START is a 7-bit device address, sent MSB first, followed by a direction bit (0 = write, 1 = read). The target ACKs it only if the address equals `DEV_ADDR`. On a mismatch it sends no ACK and ignores all bytes until the next START.
- R2: In a write transaction, the first byte after the acknowledged address loads the register pointer. Only bits [2:0] of that byte select the register; bits [7:3] are ignored.
- R3: The target ACKs every byte it receives in a selected write transaction by pulling SDA low during the ninth SCL pulse.
- R4: A received data byte is written into the selected register on the SCL falling edge that starts its ACK bit. It is visible on `regs_o` while the ACK clock is high, before any STOP. Register n appears on `regs_o[8n+7:8n]`.
- R5: The pointer advances by one after every data byte written or read, and wraps from 7 to 0.
- R6: A repeated START followed by the device address with the direction bit set keeps the pointer unchanged. The target then sends the byte at the pointer, MSB first.
- R7: When the controller ACKs a read byte, the target sends the next register. A run of eight reads starting at register k returns registers k, k+1, … modulo 8.
- R8: When the controller NACKs a read byte, the target releases SDA and sends nothing more until the next START.
- R9: A STOP or a START in the middle of a byte aborts the transfer. The partly received byte is never written.
- R10: The target changes its SDA drive only while SCL is low.
- R11: After reset, all eight registers are 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line, sampled |
| sda_i | input | 1 | I2C data line, sampled |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| regs_o | output | 64 | All eight registers; register n is on bits [8n+7:8n] |

## Verification
The bench drives several kinds of transaction:
- A wrong device address. This separates address matching from bare byte reception.
- A single-byte write, and a four-byte write starting at register 6. The four-byte write separates a wrapping pointer from a saturating one.
- A pointer byte with its upper bits set. This shows that only the low three bits are decoded.
- A single read with NACK, and an eight-byte read starting at register 5. The eight-byte read shows both the wrap and that the pointer survives the repeated START.
- Transfers aborted by STOP and by repeated START part-way through a byte. These show that nothing is committed early.

A behavioural register model is compared with `regs_o` on every clock. This shows each write landing during its ACK, not at STOP.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REGPTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } rb_state_t;
endpackage

// File: rtl/i2c_rb_linesync.sv
// Synchroniser for the bus lines, plus SCL edge and START/STOP detection
module i2c_rb_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic scl_p, sda_p;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= scl_i;
                    sda_q <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[STAGES-2:0], scl_i};
                    sda_q <= {sda_q[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_rb_regfile.sv
// Register bank with a single write port; every entry is visible in parallel
module i2c_rb_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [DW-1:0]      wdata,
    output logic [NREG*DW-1:0] q
);
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            localparam logic [AW-1:0] IDX = AW'(g);
            logic [DW-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    r <= '0;
                else if (we && waddr == IDX)
                    r <= wdata;
            end
            assign q[g*DW +: DW] = r;
        end
    endgenerate
endmodule

// File: rtl/i2c_regbank_slave.sv
// I2C target that gives a controller access to a bank of configuration registers
module i2c_regbank_slave #(
    parameter logic [6:0] DEV_ADDR = 7'h2C,
    parameter int         NREG     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe,
    output logic [NREG*8-1:0] regs_o
);
    import i2c_rb_pkg::*;

    localparam int AW = $clog2(NREG);
    localparam logic [3:0] FULL = 4'd8;
    localparam logic [3:0] LAST = 4'd7;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    rb_state_t state;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic [AW-1:0] ptr, ptr_inc;
    logic          rw, mack;
    logic          we;
    logic [7:0]    rd_byte;

    i2c_rb_linesync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_rb_regfile #(.NREG(NREG), .DW(8)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(ptr), .wdata(shreg), .q(regs_o)
    );

    assign ptr_inc = (ptr == AW'(NREG-1)) ? '0 : ptr + 1'b1;
    assign rd_byte = regs_o[{ptr, 3'b000} +: 8];

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            ptr    <= '0;
            rw     <= 1'b0;
            mack   <= 1'b0;
        end else if (start_det) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR, ST_REGPTR, ST_WDATA: begin
                    if (scl_rise && bitcnt != FULL) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == FULL) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                rw    <= shreg[0];
                                state <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (state == ST_REGPTR) begin
                            ptr   <= shreg[AW-1:0];
                            state <= ST_PTR_ACK;
                        end else begin
                            ptr   <= ptr_inc;
                            state <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            shreg <= rd_byte;
                            ptr   <= ptr_inc;
                            state <= ST_RDATA;
                        end else begin
                            state <= ST_REGPTR;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        state  <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bitcnt == LAST) begin
                            bitcnt <= '0;
                            state  <= ST_RACK;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise)
                        mack <= ~sda_s;
                    else if (scl_fall) begin
                        if (mack) begin
                            shreg <= rd_byte;
                            ptr   <= ptr_inc;
                            state <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        we = (state == ST_WDATA) && scl_fall && (bitcnt == FULL)
             && !start_det && !stop_det;
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~shreg[7];
            default:                               sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk #(
    parameter logic [6:0] DEV_ADDR = 7'h2C,
    parameter int         NREG     = 8,
    localparam int        AW       = $clog2(NREG)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    scl_s,
    input logic                    stop_det,
    input i2c_rb_pkg::rb_state_t   state,
    input logic [AW-1:0]           ptr,
    input logic [7:0]              shreg,
    input logic                    sda_oe,
    input logic [NREG*8-1:0]       regs_o
);
    import i2c_rb_pkg::*;

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sda_oe) |-> !$past(scl_s)); // R10

    AST_ACK_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |-> ($past(shreg[7:1]) == DEV_ADDR)); // R1

    AST_COMMIT_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> state == ST_WDATA_ACK); // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(ptr) && state != ST_PTR_ACK)
        |-> ptr == (($past(ptr) == AW'(NREG-1)) ? '0 : $past(ptr) + 1'b1)); // R5

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == ST_IDLE); // R9

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RACK |-> !sda_oe); // R8
endmodule

bind i2c_regbank_slave i2c_rb_chk #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det), .state(state),
    .ptr(ptr), .shreg(shreg), .sda_oe(sda_oe), .regs_o(regs_o)
);

// File: tb/i2c_regbank_slave_bench.sv
module i2c_regbank_slave_bench;
    localparam logic [6:0] ADDR = 7'h2C;
    localparam int HALF = 12;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1;
    logic sda_oe;
    logic [63:0] regs_o;
    wire sda_line = msda & ~sda_oe;

    always #2 clk = ~clk;

    i2c_regbank_slave #(.DEV_ADDR(ADDR), .NREG(8)) u_i2c_regbank_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .regs_o(regs_o)
    );

    int total = 0, bad = 0;
    bit cmp_en = 1'b0, done = 1'b0;
    logic [7:0] mregs [8];
    int mptr = 0;
    logic prev_oe = 1'b0, prev_scl = 1'b1;

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int i = 0; i < 8; i++) f[i*8 +: 8] = mregs[i];
        return f;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Every clock: register model vs regs_o (R4), drive changes only with SCL low (R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cmp_en && regs_o !== model_flat()) begin
                bad++;
                $display("FAIL R4 per-clock regs actual=%h expected=%h", regs_o, model_flat());
            end
            if (sda_oe !== prev_oe && scl && prev_scl) begin
                bad++;
                $display("FAIL R10 sda_oe changed with SCL high actual=%b expected=%b", sda_oe, prev_oe);
            end
        end
        prev_oe  = sda_oe;
        prev_scl = scl;
    end

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        msda = 1'b1; hw(HALF);
        scl = 1'b1;  hw(HALF);
        msda = 1'b0; hw(HALF);
        scl = 1'b0;  hw(2);
    endtask

    task automatic bus_stop();
        msda = 1'b0; hw(HALF);
        scl = 1'b1;  hw(HALF);
        msda = 1'b1; hw(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            msda = b[i]; hw(HALF);
            scl = 1'b1;  hw(HALF);
            scl = 1'b0;  hw(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit is_data, output bit ack);
        send_bits(b, 8);
        if (is_data) cmp_en = 1'b0;
        msda = 1'b1; hw(HALF);
        scl = 1'b1;  hw(HALF/2);
        ack = !sda_line;
        if (is_data) begin
            check($sformatf("R4 reg%0d set before STOP", mptr), {56'd0, regs_o[mptr*8 +: 8]}, {56'd0, b});
            mregs[mptr] = b;
            mptr = (mptr + 1) % 8;
            cmp_en = 1'b1;
        end
        hw(HALF/2);
        scl = 1'b0; hw(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit mack);
        msda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            hw(HALF);
            scl = 1'b1; hw(HALF/2);
            b = {b[6:0], sda_line};
            hw(HALF/2);
            scl = 1'b0; hw(2);
        end
        msda = mack ? 1'b0 : 1'b1; hw(HALF);
        scl = 1'b1; hw(HALF);
        scl = 1'b0; hw(2);
        msda = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] p);
        bit a;
        bus_start();
        send_byte({ADDR, 1'b0}, 1'b0, a);
        check("R1 address ack", {63'd0, a}, 64'd1);
        send_byte(p, 1'b0, a);
        check("R3 pointer byte ack", {63'd0, a}, 64'd1);
        mptr = int'(p[2:0]);
    endtask

    initial begin
        bit a;
        logic [7:0] b;
        logic [7:0] wd [4];
        for (int i = 0; i < 8; i++) mregs[i] = 8'h00;
        hw(5);
        check("R11 regs after reset", regs_o, 64'd0);
        check("R11 sda released at reset", {63'd0, sda_oe}, 64'd0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        hw(10);

        // R1: wrong device address is not acknowledged; later bytes ignored
        bus_start();
        send_byte({7'h13, 1'b0}, 1'b0, a);
        check("R1 mismatch nack", {63'd0, a}, 64'd0);
        send_byte(8'h02, 1'b0, a);
        check("R1 idle after mismatch", {63'd0, a}, 64'd0);
        send_byte(8'hFF, 1'b0, a);
        check("R1 idle after mismatch data", {63'd0, a}, 64'd0);
        bus_stop();

        // R2/R3/R4: single write to register 3
        set_ptr(8'h03);
        send_byte(8'hA5, 1'b1, a);
        check("R3 data ack", {63'd0, a}, 64'd1);
        bus_stop();

        // R5: sequential write wrapping 6,7,0,1
        wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33; wd[3] = 8'h44;
        set_ptr(8'h06);
        for (int i = 0; i < 4; i++) begin
            send_byte(wd[i], 1'b1, a);
            check("R3 seq data ack", {63'd0, a}, 64'd1);
        end
        check("R5 wrap reg0", {56'd0, regs_o[7:0]}, 64'h33);
        check("R5 wrap reg1", {56'd0, regs_o[15:8]}, 64'h44);
        bus_stop();

        // R2: upper pointer bits ignored (0xFA selects register 2)
        set_ptr(8'hFA);
        send_byte(8'h5C, 1'b1, a);
        bus_stop();
        check("R2 low bits select reg2", {56'd0, regs_o[23:16]}, 64'h5C);

        // R6: random read of register 3 through repeated START
        set_ptr(8'h03);
        bus_start();
        send_byte({ADDR, 1'b1}, 1'b0, a);
        check("R6 read address ack", {63'd0, a}, 64'd1);
        recv_byte(b, 1'b0);
        check("R6 read reg3", {56'd0, b}, {56'd0, mregs[3]});
        check("R8 released after nack", {63'd0, sda_oe}, 64'd0);
        bus_stop();

        // R7: sequential read from register 5, wraps
        set_ptr(8'h05);
        bus_start();
        send_byte({ADDR, 1'b1}, 1'b0, a);
        for (int i = 0; i < 8; i++) begin
            recv_byte(b, i != 7);
            check($sformatf("R7 seq read %0d", i), {56'd0, b}, {56'd0, mregs[(5 + i) % 8]});
        end
        // R8: after NACK the target sends nothing
        recv_byte(b, 1'b0);
        check("R8 no drive after nack", {56'd0, b}, 64'hFF);
        bus_stop();

        // R9: STOP in the middle of a data byte
        set_ptr(8'h04);
        send_bits(8'h0F, 4);
        bus_stop();
        check("R9 reg4 unchanged after stop", {56'd0, regs_o[39:32]}, {56'd0, mregs[4]});

        // R9: repeated START in the middle of a data byte, then a new write
        set_ptr(8'h01);
        send_bits(8'h00, 3);
        set_ptr(8'h07);
        send_byte(8'h77, 1'b1, a);
        bus_stop();
        check("R9 reg1 unchanged after restart", {56'd0, regs_o[15:8]}, {56'd0, mregs[1]});
        check("R9 reg7 written after restart", {56'd0, regs_o[63:56]}, 64'h77);

        hw(20);
        total++; // per-clock register and drive comparison (R4, R10)
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule